// File: doc/BRIEF.md
# Four-Way Set-Associative Write-Back Data Cache

This block is a data cache of 8 KB that sits between a core's load/store unit and a line-wide memory. It has 64-byte lines in four ways of 32 sets. Every cycle it accepts one load and one store. Each request is held in a stage register. In the next cycle, the four tags of the addressed set are compared at the same time, and the hitting way steers the line data. The result is registered, so a hit answers two cycles after it was presented, and a new pair of requests can enter every cycle.

When either held request misses, the cache stalls both ports. It picks a victim way in the set: an invalid way if there is one, otherwise the least recently used way. A dirty victim is first written back to memory as a whole line. The missing line is then read in, and the held requests are looked up again. Stores write only their enabled bytes and mark the line dirty. A load that meets a store to the same word in the same cycle sees the stored bytes.

Top module: `setassoc_cache`

## Requirements
- R1: An address splits into tag bits [31:11], set bits [10:6] and line offset bits [5:0]. A load returns the 32-bit word at offset bits [5:2]. Line byte k sits at bits [8k+7:8k] of the line bus, and word byte b is line byte 4*offset[5:2]+b.
- R2: A load or store that hits, presented in the cycle before clock edge k, gives its response valid with hit=1 after edge k+1.
- R3: Hitting requests are accepted on consecutive cycles with `busy` low, and their responses follow one per cycle in order.
- R4: A load and a store presented in the same cycle are both served in that pipeline slot when both hit.
- R5: When a load and a store in the same cycle address the same word, the load returns the store's enabled bytes merged with the old bytes.
- R6: On a miss, `busy` stays high while a line read of the line-aligned miss address is issued. The response then arrives with hit=0 and data taken from the filled line.
- R7: A dirty victim is written back as a whole line, at its own line address, before the refill read. A clean victim is never written back, and written data survives eviction and refill.
- R8: The victim is an invalid way when one exists, otherwise the least recently used way of the set. Hits and fills both count as uses.
- R9: A store writes only the bytes whose byte enable bit b is set (bit b covers data bits [8b+7:8b]). The other bytes of the word keep their values.
- R10: After reset `busy`, both response valids and `memReq` are low, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ldValid | input | 1 | Load request present |
| ldAddr | input | 32 | Load byte address |
| stValid | input | 1 | Store request present |
| stAddr | input | 32 | Store byte address |
| stData | input | 32 | Store data word |
| stBe | input | 4 | Store byte enables |
| busy | output | 1 | Requests are not accepted this cycle |
| ldRespValid | output | 1 | Load response present |
| ldRespHit | output | 1 | Load hit without a refill |
| ldRespData | output | 32 | Load data word |
| stRespValid | output | 1 | Store completed |
| stRespHit | output | 1 | Store hit without a refill |
| memReq | output | 1 | Memory line request active |
| memWe | output | 1 | Request is a write-back (1) or a refill read (0) |
| memAddr | output | 32 | Line-aligned memory address |
| memWdata | output | 512 | Write-back line data |
| memAck | input | 1 | One-cycle completion of the memory request |
| memRdata | input | 512 | Refill line data, valid with memAck |

## Verification
Loads are tried as cold misses, as single hits and as a stream of hits to one line. The cold misses check the refill address and the word selection. The single hits check the exact two-cycle latency, and the stream shows that no bubble appears. Stores are tried with a partial byte-enable mask to show lane isolation. Paired load/store requests are tried in two forms: to different sets, which shows that both ports work in one slot, and to the same word, which shows the forwarded bytes. A scripted sequence of conflicting lines in one set separates true LRU order from other victim orders. It evicts a clean line with no write-back and a dirty line with exactly one write-back, and the dirty line is then reloaded to show that its data came back intact.

// File: rtl/cache_pkg.sv
package cache_pkg;
  parameter int ADDR_W     = 32;
  parameter int LINE_BYTES = 64;
  parameter int WAYS       = 4;
  parameter int SETS       = 32;
  parameter int WORD_W     = 32;

  localparam int OFF_W      = $clog2(LINE_BYTES);
  localparam int IDX_W      = $clog2(SETS);
  localparam int TAG_W      = ADDR_W - IDX_W - OFF_W;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int BSEL_W     = $clog2(WORD_BYTES);
  localparam int WSEL_W     = $clog2(LINE_BYTES / WORD_BYTES);
  localparam int WAY_W      = $clog2(WAYS);
  localparam int AGE_W      = WAY_W;

  // strobes from control to datapath
  typedef struct packed {
    logic advance;   // held requests complete, new ones enter
    logic fill;      // refill line arrives this cycle
    logic svcStore;  // miss being serviced belongs to the store port
    logic wbPhase;   // memory address points at the victim
  } ctrlStrobe_t;
endpackage

// File: rtl/cache_ctrl.sv
module cache_ctrl
  import cache_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ldMiss,
  input  logic        stMiss,
  input  logic        victimDirty,
  input  logic        memAck,
  output ctrlStrobe_t strobe,
  output logic        busy,
  output logic        memReq,
  output logic        memWe
);
  typedef enum logic [1:0] {S_IDLE, S_WRBACK, S_REFILL} phase_t;
  phase_t phase, phaseNext;

  always_comb begin
    phaseNext = phase;
    case (phase)
      S_IDLE:   if (ldMiss || stMiss) phaseNext = victimDirty ? S_WRBACK : S_REFILL;
      S_WRBACK: if (memAck) phaseNext = S_REFILL;
      S_REFILL: if (memAck) phaseNext = S_IDLE;
      default:  phaseNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= S_IDLE;
    else       phase <= phaseNext;
  end

  assign strobe.advance  = (phase == S_IDLE) && !ldMiss && !stMiss;
  assign strobe.fill     = (phase == S_REFILL) && memAck;
  assign strobe.svcStore = !ldMiss;
  assign strobe.wbPhase  = (phase == S_WRBACK);
  assign busy            = !strobe.advance;
  assign memReq          = (phase != S_IDLE);
  assign memWe           = (phase == S_WRBACK);
endmodule

// File: rtl/cache_dpath.sv
module cache_dpath
  import cache_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           strobe,
  input  logic                  ldValid,
  input  logic [ADDR_W-1:0]     ldAddr,
  input  logic                  stValid,
  input  logic [ADDR_W-1:0]     stAddr,
  input  logic [WORD_W-1:0]     stData,
  input  logic [WORD_BYTES-1:0] stBe,
  input  logic [LINE_W-1:0]     memRdata,
  output logic                  ldMiss,
  output logic                  stMiss,
  output logic                  victimDirty,
  output logic                  ldRespValid,
  output logic                  ldRespHit,
  output logic [WORD_W-1:0]     ldRespData,
  output logic                  stRespValid,
  output logic                  stRespHit,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [LINE_W-1:0]     memWdata
);
  typedef logic [WAYS-1:0][AGE_W-1:0] ages_t;

  logic [TAG_W-1:0]  tagArr   [WAYS][SETS];
  logic [LINE_W-1:0] dataArr  [WAYS][SETS];
  logic [SETS-1:0]   validArr [WAYS];
  logic [SETS-1:0]   dirtyArr [WAYS];
  ages_t             lruArr   [SETS];

  // held request stage
  logic                  rLdVld, rStVld, ldMissedR, stMissedR;
  logic [ADDR_W-1:0]     rLdAddr, rStAddr;
  logic [WORD_W-1:0]     rStData;
  logic [WORD_BYTES-1:0] rStBe;

  wire [IDX_W-1:0]  ldIdx  = rLdAddr[OFF_W +: IDX_W];
  wire [IDX_W-1:0]  stIdx  = rStAddr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  ldTag  = rLdAddr[ADDR_W-1 -: TAG_W];
  wire [TAG_W-1:0]  stTag  = rStAddr[ADDR_W-1 -: TAG_W];
  wire [WSEL_W-1:0] ldWsel = rLdAddr[BSEL_W +: WSEL_W];
  wire [WSEL_W-1:0] stWsel = rStAddr[BSEL_W +: WSEL_W];
  wire [ADDR_W-1:0] svcAddr = strobe.svcStore ? rStAddr : rLdAddr;
  wire [IDX_W-1:0]  svcIdx  = svcAddr[OFF_W +: IDX_W];
  wire [TAG_W-1:0]  svcTag  = svcAddr[ADDR_W-1 -: TAG_W];

  logic [WAYS-1:0]  ldHitW, stHitW, invW;
  logic [WAY_W-1:0] ldWay, stWay, vicWay;
  logic [LINE_W-1:0] ldLine;
  logic [WORD_W-1:0] ldWord, fwdWord;
  ages_t stAges, ldAges, fillAges;

  function automatic ages_t touch(ages_t a, logic [WAY_W-1:0] w);
    ages_t r;
    for (int i = 0; i < WAYS; i++)
      if (WAY_W'(i) == w)  r[i] = '0;
      else if (a[i] < a[w]) r[i] = AGE_W'(a[i] + 1'b1);
      else                 r[i] = a[i];
    return r;
  endfunction

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign ldHitW[w] = validArr[w][ldIdx] && (tagArr[w][ldIdx] == ldTag);
    assign stHitW[w] = validArr[w][stIdx] && (tagArr[w][stIdx] == stTag);
    assign invW[w]   = !validArr[w][svcIdx];
  end

  assign ldMiss = rLdVld && !(|ldHitW);
  assign stMiss = rStVld && !(|stHitW);

  always_comb begin
    ldWay  = '0;
    stWay  = '0;
    vicWay = '0;
    ldLine = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (ldHitW[w]) begin
        ldWay  = WAY_W'(w);
        ldLine = ldLine | dataArr[w][ldIdx];
      end
      if (stHitW[w]) stWay = WAY_W'(w);
      if (lruArr[svcIdx][w] == AGE_W'(WAYS - 1)) vicWay = WAY_W'(w);
    end
    for (int w = WAYS - 1; w >= 0; w--)
      if (invW[w]) vicWay = WAY_W'(w);
  end

  always_comb begin
    ldWord  = ldLine[int'(ldWsel) * WORD_W +: WORD_W];
    fwdWord = ldWord;
    for (int b = 0; b < WORD_BYTES; b++)
      if (rStVld && rStBe[b] && (rLdAddr[ADDR_W-1:BSEL_W] == rStAddr[ADDR_W-1:BSEL_W]))
        fwdWord[b*8 +: 8] = rStData[b*8 +: 8];
  end

  always_comb begin
    stAges   = touch(lruArr[stIdx], stWay);
    ldAges   = touch((rStVld && stIdx == ldIdx) ? stAges : lruArr[ldIdx], ldWay);
    fillAges = touch(lruArr[svcIdx], vicWay);
  end

  assign victimDirty = validArr[vicWay][svcIdx] && dirtyArr[vicWay][svcIdx];
  assign memAddr  = strobe.wbPhase ? {tagArr[vicWay][svcIdx], svcIdx, {OFF_W{1'b0}}}
                                   : {svcTag, svcIdx, {OFF_W{1'b0}}};
  assign memWdata = dataArr[vicWay][svcIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < WAYS; w++) begin
        validArr[w] <= '0;
        dirtyArr[w] <= '0;
      end
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) lruArr[s][w] <= AGE_W'(w);
      {rLdVld, rStVld, ldMissedR, stMissedR} <= '0;
      {ldRespValid, ldRespHit, stRespValid, stRespHit} <= '0;
      rLdAddr <= '0; rStAddr <= '0; rStData <= '0; rStBe <= '0;
      ldRespData <= '0;
    end else begin
      if (strobe.advance) begin
        rLdVld <= ldValid;  rLdAddr <= ldAddr;
        rStVld <= stValid;  rStAddr <= stAddr;
        rStData <= stData;  rStBe <= stBe;
        ldRespValid <= rLdVld;
        ldRespHit   <= !ldMissedR;
        ldRespData  <= fwdWord;
        stRespValid <= rStVld;
        stRespHit   <= !stMissedR;
        ldMissedR   <= 1'b0;
        stMissedR   <= 1'b0;
        if (rStVld) begin
          dirtyArr[stWay][stIdx] <= 1'b1;
          lruArr[stIdx] <= stAges;
        end
        if (rLdVld) lruArr[ldIdx] <= ldAges;
      end else begin
        ldRespValid <= 1'b0;
        stRespValid <= 1'b0;
        if (ldMiss) ldMissedR <= 1'b1;
        if (stMiss) stMissedR <= 1'b1;
      end
      if (strobe.fill) begin
        validArr[vicWay][svcIdx] <= 1'b1;
        dirtyArr[vicWay][svcIdx] <= 1'b0;
        lruArr[svcIdx] <= fillAges;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.fill) begin
      dataArr[vicWay][svcIdx] <= memRdata;
      tagArr[vicWay][svcIdx]  <= svcTag;
    end
    if (strobe.advance && rStVld)
      for (int b = 0; b < WORD_BYTES; b++)
        if (rStBe[b])
          dataArr[stWay][stIdx][(int'(stWsel) * WORD_BYTES + b) * 8 +: 8] <= rStData[b*8 +: 8];
  end
endmodule

// File: rtl/setassoc_cache.sv
module setassoc_cache
  import cache_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  ldValid,
  input  logic [ADDR_W-1:0]     ldAddr,
  input  logic                  stValid,
  input  logic [ADDR_W-1:0]     stAddr,
  input  logic [WORD_W-1:0]     stData,
  input  logic [WORD_BYTES-1:0] stBe,
  output logic                  busy,
  output logic                  ldRespValid,
  output logic                  ldRespHit,
  output logic [WORD_W-1:0]     ldRespData,
  output logic                  stRespValid,
  output logic                  stRespHit,
  output logic                  memReq,
  output logic                  memWe,
  output logic [ADDR_W-1:0]     memAddr,
  output logic [LINE_W-1:0]     memWdata,
  input  logic                  memAck,
  input  logic [LINE_W-1:0]     memRdata
);
  ctrlStrobe_t strobe;
  logic ldMiss, stMiss, victimDirty;

  cache_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ldMiss(ldMiss), .stMiss(stMiss),
    .victimDirty(victimDirty), .memAck(memAck), .strobe(strobe),
    .busy(busy), .memReq(memReq), .memWe(memWe)
  );

  cache_dpath u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ldValid(ldValid), .ldAddr(ldAddr),
    .stValid(stValid), .stAddr(stAddr), .stData(stData), .stBe(stBe),
    .memRdata(memRdata), .ldMiss(ldMiss), .stMiss(stMiss), .victimDirty(victimDirty),
    .ldRespValid(ldRespValid), .ldRespHit(ldRespHit), .ldRespData(ldRespData),
    .stRespValid(stRespValid), .stRespHit(stRespHit),
    .memAddr(memAddr), .memWdata(memWdata)
  );
endmodule

// File: rtl/setassoc_cache_chk.sv
module setassoc_cache_chk
  import cache_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic              ldRespValid,
  input logic              stRespValid,
  input logic              memReq,
  input logic              memWe,
  input logic              memAck,
  input logic [ADDR_W-1:0] memAddr
);
  // R6: ports stay stalled for the whole memory transaction
  a_r6_busy_while_mem: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> busy);

  // R6: an open request keeps its kind and address until acknowledged
  a_r6_req_held: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R6: memory addresses are whole lines
  a_r6_line_aligned: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memAddr[OFF_W-1:0] == '0));

  // R7: a finished write-back is followed at once by the refill read
  a_r7_fill_follows_wb: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && memWe && memAck) |=> (memReq && !memWe));

  // R2: no response completes while a line transfer is in progress
  a_r2_no_resp_during_refill: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> (!ldRespValid && !stRespValid));
endmodule

bind setassoc_cache setassoc_cache_chk u_chk (.*);

// File: tb/setassoc_cache_bench.sv
module setassoc_cache_bench;
  logic clk = 1'b0, rstN = 1'b0;
  logic ldValid = 0, stValid = 0, memAck = 0;
  logic [31:0] ldAddr = 0, stAddr = 0, stData = 0;
  logic [3:0]  stBe = 0;
  logic [511:0] memRdata = '0;
  logic busy, ldRespValid, ldRespHit, stRespValid, stRespHit, memReq, memWe;
  logic [31:0] ldRespData, memAddr;
  logic [511:0] memWdata;

  int checks = 0, errors = 0;
  int wbCount = 0, fillCount = 0, memCnt = 0;
  logic [31:0] lastWbAddr = 0, lastFillAddr = 0;
  logic [31:0] shadow [int];
  logic [31:0] memWords [int];

  setassoc_cache u_setassoc_cache (.*);

  always #4 clk = ~clk;

  function automatic logic [31:0] pat(int wa);
    return {16'(wa) ^ 16'hC3A5, 16'(wa)};
  endfunction

  function automatic logic [31:0] memWord(int wa);
    return memWords.exists(wa) ? memWords[wa] : pat(wa);
  endfunction

  function automatic logic [31:0] expWord(logic [31:0] a);
    int wa = int'(a >> 2);
    return shadow.exists(wa) ? shadow[wa] : pat(wa);
  endfunction

  // behavioural line memory, acknowledges after three cycles
  always @(negedge clk) begin
    if (!rstN || memAck) begin
      memAck = 1'b0; memCnt = 0;
    end else if (memReq) begin
      memCnt++;
      if (memCnt == 3) begin
        memAck = 1'b1;
        if (memWe) begin
          wbCount++; lastWbAddr = memAddr;
          for (int w = 0; w < 16; w++) memWords[int'(memAddr >> 2) + w] = memWdata[w*32 +: 32];
        end else begin
          fillCount++; lastFillAddr = memAddr;
          for (int w = 0; w < 16; w++) memRdata[w*32 +: 32] = memWord(int'(memAddr >> 2) + w);
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  // issue a load alone, check hit flag, data and (for hits) latency
  task automatic doLoad(input logic [31:0] a, input bit expHit, input string req);
    logic [31:0] exp;
    int n;
    exp = expWord(a);
    @(negedge clk); ldValid = 1; ldAddr = a;
    waitIdle();
    @(negedge clk); ldValid = 0;
    @(negedge clk); n = 1;
    while (!ldRespValid) begin @(negedge clk); n++; end
    chk(ldRespHit == expHit, req, "load hit flag", 32'(ldRespHit), 32'(expHit));
    chk(ldRespData == exp, req, "load data", ldRespData, exp);
    if (expHit) chk(n == 1, "R2", "hit latency", n, 1);
  endtask

  task automatic doStore(input logic [31:0] a, input logic [31:0] d, input logic [3:0] be,
                         input bit expHit, input string req);
    logic [31:0] w;
    w = expWord(a);
    for (int b = 0; b < 4; b++) if (be[b]) w[b*8 +: 8] = d[b*8 +: 8];
    shadow[int'(a >> 2)] = w;
    @(negedge clk); stValid = 1; stAddr = a; stData = d; stBe = be;
    waitIdle();
    @(negedge clk); stValid = 0;
    @(negedge clk);
    while (!stRespValid) @(negedge clk);
    chk(stRespHit == expHit, req, "store hit flag", 32'(stRespHit), 32'(expHit));
  endtask

  // load and store presented together; both expected to hit
  task automatic doPair(input logic [31:0] la, input logic [31:0] sa, input logic [31:0] d,
                        input logic [3:0] be, input string req);
    logic [31:0] w, exp;
    w = expWord(sa);
    for (int b = 0; b < 4; b++) if (be[b]) w[b*8 +: 8] = d[b*8 +: 8];
    shadow[int'(sa >> 2)] = w;
    exp = expWord(la);
    @(negedge clk);
    ldValid = 1; ldAddr = la; stValid = 1; stAddr = sa; stData = d; stBe = be;
    chk(busy == 0, "R4", "busy with pair", 32'(busy), 0);
    @(negedge clk); ldValid = 0; stValid = 0;
    @(negedge clk);
    chk(ldRespValid && stRespValid, "R4", "both responses", {ldRespValid, stRespValid}, 32'h3);
    chk(ldRespHit && stRespHit, "R4", "both hit", {ldRespHit, stRespHit}, 32'h3);
    chk(ldRespData == exp, req, "paired load data", ldRespData, exp);
  endtask

  localparam logic [31:0] L0 = (32'h10 << 11) | (32'd3 << 6);
  localparam logic [31:0] L7 = (32'h20 << 11) | (32'd7 << 6);

  function automatic logic [31:0] setLine(int t);
    return (32'(t) << 11) | (32'd3 << 6);
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(busy == 0, "R10", "busy after reset", 32'(busy), 0);
    chk(!ldRespValid && !stRespValid, "R10", "responses after reset", {ldRespValid, stRespValid}, 0);
    chk(memReq == 0, "R10", "memReq after reset", 32'(memReq), 0);
  endtask

  task automatic t_miss_fill();
    doLoad(L0 + 32'h24, 1'b0, "R6");   // cold: every line starts invalid (R10)
    chk(fillCount == 1, "R6", "fill count", fillCount, 1);
    chk(lastFillAddr == L0, "R6", "fill address", lastFillAddr, L0);
    chk(wbCount == 0, "R7", "no write-back on invalid victim", wbCount, 0);
    doLoad(L0 + 32'h3C, 1'b1, "R1");   // last word of the line
    doLoad(L0 + 32'h00, 1'b1, "R1");
  endtask

  task automatic t_stream();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        chk(ldRespValid == 1, "R3", "stream response", 32'(ldRespValid), 1);
        chk(ldRespData == expWord(L0 + 32'(4 * (i - 2))), "R3", "stream data",
            ldRespData, expWord(L0 + 32'(4 * (i - 2))));
      end
      if (i < 4) begin
        chk(busy == 0, "R3", "busy during stream", 32'(busy), 0);
        ldValid = 1; ldAddr = L0 + 32'(4 * i);
      end else ldValid = 0;
    end
  endtask

  task automatic t_bytes();
    doStore(L0 + 32'h10, 32'hDEADBEEF, 4'b0101, 1'b1, "R9");
    doLoad(L0 + 32'h10, 1'b1, "R9");
  endtask

  task automatic t_dual();
    doLoad(L7 + 32'h0, 1'b0, "R6");
    doPair(L7 + 32'h4, L0 + 32'h14, 32'hCAFE0001, 4'b1111, "R4");
    doLoad(L0 + 32'h14, 1'b1, "R4");
    doPair(L0 + 32'h18, L0 + 32'h18, 32'h12345678, 4'b0011, "R5");
  endtask

  task automatic t_lru();
    int wb0;
    wb0 = wbCount;
    doLoad(setLine(16'h11), 1'b0, "R8");
    doLoad(setLine(16'h12), 1'b0, "R8");
    doLoad(setLine(16'h13), 1'b0, "R8");
    doLoad(L0 + 32'h10, 1'b1, "R8");
    doLoad(setLine(16'h14), 1'b0, "R8");   // evicts 0x11 (clean)
    chk(wbCount == wb0, "R7", "clean victim not written", wbCount, wb0);
    doLoad(setLine(16'h11), 1'b0, "R8");   // was evicted
    doLoad(L0 + 32'h10, 1'b1, "R8");       // recently used survivor
    doLoad(setLine(16'h15), 1'b0, "R8");
    doLoad(setLine(16'h16), 1'b0, "R8");
    doLoad(setLine(16'h17), 1'b0, "R8");
    chk(wbCount == wb0, "R7", "still no write-back", wbCount, wb0);
    doLoad(setLine(16'h18), 1'b0, "R8");   // evicts dirty 0x10
    chk(wbCount == wb0 + 1, "R7", "dirty victim written", wbCount, wb0 + 1);
    chk(lastWbAddr == L0, "R7", "write-back address", lastWbAddr, L0);
    doLoad(L0 + 32'h10, 1'b0, "R7");       // round trip of stored bytes
    doLoad(L0 + 32'h18, 1'b1, "R7");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_miss_fill();
    t_stream();
    t_bytes();
    t_dual();
    t_lru();
    repeat (2) @(negedge clk);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
  end
endmodule